// File: doc/BRIEF.md
# Parallel Dithered Sine Synthesizer

This block produces a stream of sinusoid samples at a rate of several samples per clock. A wide converter running at full sample rate consumes the whole group on every cycle. A programmable phase step sets the output frequency. One accumulator advances by the group width times that step on each cycle. A fixed number of lanes then derive their own phases from it, each lane one step further along than the lane before it.

Phase truncation on its own leaves a periodic error that shows up as spurs in the spectrum. Each lane therefore adds a pseudo-random value, narrower than one table address step, to the fractional part of its phase before it keeps the top bits. The fractional part is the part that truncation throws away. The random values come from a maximal-length shift register that belongs to the lane. The kept bits index a table that stores a whole sine period, with no quadrant folding, and the result is registered onto the output bus.

Software writes a new phase step through a single write strobe. All lanes pick up the new step in the same cycle, so the lanes never disagree about the frequency.

Top module: `dds_parallel_sine`

## Requirements
- R1: While `rst` is high, `valid_o` is 0 and every lane of `samples_o` is 0.
- R2: `valid_o` stays 0 after the first rising edge at which `rst` is sampled low. It is 1 after the second such edge and stays 1 until reset.
- R3: A rising edge with `inc_we` high loads `inc_wdata` as the phase step. With `inc_we` low the step holds and `inc_wdata` has no effect. Reset clears the step to 0.
- R4: The accumulator resets to 0 and advances by NLANES times the step on every edge, modulo 2^PHASE_W. On each edge lane k registers the accumulator value plus k times the step, both taken before that edge.
- R5: The sample on lane k after edge t comes from the lane-k phase registered at edge t-1. Two edges separate a step or accumulator value from the sample built from it.
- R6: Table entry a (0 <= a < 2^ADDR_W) holds round(P * sin(2*pi*a / 2^ADDR_W)), with P = 2^(AMP_W-1)-1 and ties rounded away from zero, over the full period.
- R7: The table address is the top ADDR_W bits of (phase + d) modulo 2^PHASE_W, where 0 <= d < 2^(PHASE_W-ADDR_W). The address is therefore the truncated phase address or the next one, wrapping. When the low PHASE_W-ADDR_W phase bits are zero, it is exactly the truncated address.
- R8: Each lane's d is the top PHASE_W-ADDR_W bits of the lane's 16-bit register state followed by zeros. The register steps with feedback polynomial x^16+x^14+x^13+x^11+1 and starts from a distinct nonzero per-lane seed. It is never all zeros, and no two lanes hold the same state.
- R9: For a step with a nonzero fractional part, both neighbouring table entries appear on the outputs over a few hundred cycles.
- R10: Lane k occupies `samples_o[k*AMP_W +: AMP_W]` as two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inc_we | input | 1 | Write strobe for the phase step |
| inc_wdata | input | PHASE_W | New phase step |
| samples_o | output | NLANES*AMP_W | One signed sample per lane, lane 0 in the low bits |
| valid_o | output | 1 | Samples on the bus are meaningful |

## Verification
The bench builds the block with four lanes, a 16-bit phase, a 6-bit table address and 12-bit samples. With these values the 64-entry table is walked end to end within a few cycles. A step of exactly one address checks every entry with no dither ambiguity, and a fractional step shows both dither outcomes many times within a short run. A negative step covers wrap-around of the phase in the reverse direction. Bursts of step writes on consecutive cycles check that lane coherence holds across changes.

// File: rtl/dds_pkg.sv
package dds_pkg;

  // Width of the per-lane dither shift register.
  localparam int LFSR_W = 16;

  // One Fibonacci step of x^16+x^14+x^13+x^11+1 (maximal length).
  function automatic logic [LFSR_W-1:0] lfsr_step(logic [LFSR_W-1:0] s);
    logic fb;
    fb = s[15] ^ s[13] ^ s[12] ^ s[10];
    return {s[LFSR_W-2:0], fb};
  endfunction

  // Distinct nonzero starting state for each lane index.
  function automatic logic [LFSR_W-1:0] lane_seed(int lane);
    logic [LFSR_W-1:0] v;
    v = 16'hACE1 ^ (16'(lane) * 16'h9E37);
    if (v == '0) v = 16'h8001;
    return v;
  endfunction

endpackage

// File: rtl/dds_phase_ctrl.sv
module dds_phase_ctrl #(
  parameter int NLANES  = 4,
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inc_we,
  input  logic [PHASE_W-1:0] inc_wdata,
  output logic [PHASE_W-1:0] inc_q,
  output logic [PHASE_W-1:0] base_q
);

  localparam logic [PHASE_W-1:0] GROUP = PHASE_W'(NLANES);

  // Phase advance of one whole group of lanes.
  function automatic logic [PHASE_W-1:0] group_advance(logic [PHASE_W-1:0] b,
                                                       logic [PHASE_W-1:0] step);
    return b + GROUP * step;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      inc_q  <= '0;
      base_q <= '0;
    end else begin
      if (inc_we) inc_q <= inc_wdata;
      base_q <= group_advance(base_q, inc_q);
    end
  end

endmodule

// File: rtl/dds_lane.sv
module dds_lane
  import dds_pkg::*;
#(
  parameter int LANE    = 0,
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] base_i,
  input  logic [PHASE_W-1:0] inc_i,
  output logic [PHASE_W-1:0] phase_q,
  output logic [ADDR_W-1:0]  addr_q,
  output logic [LFSR_W-1:0]  lfsr_q
);

  localparam int FRAC_W = PHASE_W - ADDR_W;
  localparam int WIDE_W = LFSR_W + FRAC_W;
  localparam logic [PHASE_W-1:0] OFFSET = PHASE_W'(LANE);

  // Lane phase: accumulator plus this lane's share of the step.
  function automatic logic [PHASE_W-1:0] lane_phase(logic [PHASE_W-1:0] b,
                                                    logic [PHASE_W-1:0] step);
    return b + OFFSET * step;
  endfunction

  // Dither below one address step: register state, left aligned in the fraction.
  function automatic logic [FRAC_W-1:0] dither_of(logic [LFSR_W-1:0] s);
    logic [WIDE_W-1:0] wide;
    wide = {s, {FRAC_W{1'b0}}};
    return wide[WIDE_W-1 -: FRAC_W];
  endfunction

  // Address after dithering and truncation.
  function automatic logic [ADDR_W-1:0] dithered_addr(logic [PHASE_W-1:0] ph,
                                                      logic [FRAC_W-1:0] d);
    logic [PHASE_W-1:0] sum;
    sum = ph + PHASE_W'(d);
    return sum[PHASE_W-1 -: ADDR_W];
  endfunction

  logic [PHASE_W-1:0] phase_d;
  logic [FRAC_W-1:0]  dith;

  assign phase_d = lane_phase(base_i, inc_i);
  assign dith    = dither_of(lfsr_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr_q  <= lane_seed(LANE);
      phase_q <= '0;
      addr_q  <= '0;
    end else begin
      lfsr_q  <= lfsr_step(lfsr_q);
      phase_q <= phase_d;
      addr_q  <= dithered_addr(phase_d, dith);
    end
  end

endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
  parameter int NPORTS = 4,
  parameter int ADDR_W = 10,
  parameter int AMP_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NPORTS*ADDR_W-1:0] addr_i,
  output logic [NPORTS*AMP_W-1:0]  data_o
);

  localparam int  DEPTH = 1 << ADDR_W;
  localparam int  PEAK  = (1 << (AMP_W - 1)) - 1;
  localparam real TAU   = 6.283185307179586;

  // Rounded full-period sine entry, ties away from zero.
  function automatic logic signed [AMP_W-1:0] sine_entry(int idx);
    real ang;
    real v;
    int  r;
    ang = TAU * real'(idx) / real'(DEPTH);
    v   = real'(PEAK) * $sin(ang);
    if (v >= 0.0) r = $rtoi(v + 0.5);
    else          r = -$rtoi(0.5 - v);
    return AMP_W'(r);
  endfunction

  logic signed [AMP_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = sine_entry(i);
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) data_o[p*AMP_W +: AMP_W] <= '0;
      else     data_o[p*AMP_W +: AMP_W] <= mem[addr_i[p*ADDR_W +: ADDR_W]];
    end
  end

endmodule

// File: rtl/dds_parallel_sine.sv
module dds_parallel_sine
  import dds_pkg::*;
#(
  parameter int NLANES  = 4,
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 10,
  parameter int AMP_W   = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inc_we,
  input  logic [PHASE_W-1:0]      inc_wdata,
  output logic [NLANES*AMP_W-1:0] samples_o,
  output logic                    valid_o
);

  localparam int LATENCY = 2;

  logic [PHASE_W-1:0]        inc_q;
  logic [PHASE_W-1:0]        base_q;
  logic [NLANES*PHASE_W-1:0] lane_phase;
  logic [NLANES*ADDR_W-1:0]  lane_addr;
  logic [NLANES*LFSR_W-1:0]  lane_lfsr;
  logic [LATENCY-1:0]        vld_sr;

  dds_phase_ctrl #(.NLANES(NLANES), .PHASE_W(PHASE_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .inc_we    (inc_we),
    .inc_wdata (inc_wdata),
    .inc_q     (inc_q),
    .base_q    (base_q)
  );

  for (genvar k = 0; k < NLANES; k++) begin : g_lane
    dds_lane #(.LANE(k), .PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) u_lane (
      .clk     (clk),
      .rst     (rst),
      .base_i  (base_q),
      .inc_i   (inc_q),
      .phase_q (lane_phase[k*PHASE_W +: PHASE_W]),
      .addr_q  (lane_addr[k*ADDR_W +: ADDR_W]),
      .lfsr_q  (lane_lfsr[k*LFSR_W +: LFSR_W])
    );
  end

  dds_sine_rom #(.NPORTS(NLANES), .ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_rom (
    .clk    (clk),
    .rst    (rst),
    .addr_i (lane_addr),
    .data_o (samples_o)
  );

  always_ff @(posedge clk) begin
    if (rst) vld_sr <= '0;
    else     vld_sr <= {vld_sr[LATENCY-2:0], 1'b1};
  end

  assign valid_o = vld_sr[LATENCY-1];

endmodule

// File: rtl/dds_parallel_sine_chk.sv
module dds_parallel_sine_chk
  import dds_pkg::*;
#(
  parameter int NLANES  = 4,
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 10
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        inc_we,
  input logic [PHASE_W-1:0]          inc_wdata,
  input logic [PHASE_W-1:0]          inc_q,
  input logic [NLANES*PHASE_W-1:0]   lane_phase,
  input logic [NLANES*ADDR_W-1:0]    lane_addr,
  input logic [NLANES*LFSR_W-1:0]    lane_lfsr,
  input logic                        valid_o
);

  localparam int LAST = NLANES - 1;

  a_r3_inc_load: assert property (@(posedge clk) disable iff (rst)
    inc_we |=> (inc_q == $past(inc_wdata)));

  a_r3_inc_hold: assert property (@(posedge clk) disable iff (rst)
    !inc_we |=> $stable(inc_q));

  a_r2_valid_late: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !valid_o);

  a_r2_valid_sticky: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> valid_o);

  if (NLANES > 1) begin : g_multi
    a_r4_group_continuity: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |->
        lane_phase[0 +: PHASE_W] ==
        $past(lane_phase[LAST*PHASE_W +: PHASE_W]) +
        $past(lane_phase[PHASE_W +: PHASE_W] - lane_phase[0 +: PHASE_W]));

    a_r8_lfsr_distinct: assert property (@(posedge clk) disable iff (rst)
      lane_lfsr[0 +: LFSR_W] != lane_lfsr[LFSR_W +: LFSR_W]);
  end

  for (genvar k = 0; k < NLANES; k++) begin : g_lane
    if (k > 0) begin : g_step
      a_r4_lane_spacing: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |->
          (lane_phase[k*PHASE_W +: PHASE_W] - lane_phase[(k-1)*PHASE_W +: PHASE_W])
          == $past(inc_q));
    end

    a_r7_dither_bound: assert property (@(posedge clk) disable iff (rst)
      ((lane_addr[k*ADDR_W +: ADDR_W]
        - lane_phase[k*PHASE_W + PHASE_W - 1 -: ADDR_W]) <= ADDR_W'(1)));

    a_r8_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst)
      lane_lfsr[k*LFSR_W +: LFSR_W] != '0);
  end

endmodule

bind dds_parallel_sine dds_parallel_sine_chk #(
  .NLANES(NLANES), .PHASE_W(PHASE_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .inc_we     (inc_we),
  .inc_wdata  (inc_wdata),
  .inc_q      (inc_q),
  .lane_phase (lane_phase),
  .lane_addr  (lane_addr),
  .lane_lfsr  (lane_lfsr),
  .valid_o    (valid_o)
);

// File: tb/sim_dds_parallel_sine.sv
module sim_dds_parallel_sine;

  localparam int CLK_PERIOD = 10;
  localparam int NL   = 4;
  localparam int PW   = 16;
  localparam int AW   = 6;
  localparam int AMPW = 12;
  localparam int DW   = PW - AW;
  localparam int D    = 1 << AW;
  localparam int WATCHDOG = 5000;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               inc_we = 1'b0;
  logic [PW-1:0]      inc_wdata = '0;
  logic [NL*AMPW-1:0] samples;
  logic               valid;

  int errs = 0;
  int total = 0;
  int hits_lo = 0;
  int hits_hi = 0;
  int cyc = 0;
  bit live = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dds_parallel_sine #(.NLANES(NL), .PHASE_W(PW), .ADDR_W(AW), .AMP_W(AMPW)) u0 (
    .clk       (clk),
    .rst       (rst),
    .inc_we    (inc_we),
    .inc_wdata (inc_wdata),
    .samples_o (samples),
    .valid_o   (valid)
  );

  // Behavioural model from R2..R5: step, accumulator, two-stage phase delay.
  logic [PW-1:0] m_inc, m_base;
  logic [PW-1:0] m_ph1 [NL];
  logic [PW-1:0] m_ph2 [NL];
  logic          m_v1, m_v2;

  always @(posedge clk) begin
    if (rst) begin
      m_inc <= '0; m_base <= '0; m_v1 <= 1'b0; m_v2 <= 1'b0;
      for (int k = 0; k < NL; k++) begin m_ph1[k] <= '0; m_ph2[k] <= '0; end
    end else begin
      if (inc_we) m_inc <= inc_wdata;
      m_base <= m_base + PW'(NL * m_inc);
      for (int k = 0; k < NL; k++) begin
        m_ph1[k] <= m_base + PW'(k * m_inc);
        m_ph2[k] <= m_ph1[k];
      end
      m_v1 <= 1'b1;
      m_v2 <= m_v1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      $display("FAIL watchdog: actual cycles=%0d expected below %0d", cyc, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errs + 1, total + 1);
      $finish;
    end
  end

  // R6: rounded sine, nearest with ties away from zero.
  function automatic int ref_sine(int a);
    real v;
    v = 2047.0 * $sin(6.283185307179586 * real'(a) / real'(D));
    return int'(v);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (live) begin
      check(valid == m_v2, "R2 valid", int'(valid), int'(m_v2));
      if (m_v2) begin
        for (int k = 0; k < NL; k++) begin
          int a, lo, hi, got;
          logic [DW-1:0] frac;
          a    = int'(m_ph2[k][PW-1 -: AW]);
          frac = m_ph2[k][DW-1:0];
          lo   = ref_sine(a);
          hi   = ref_sine((a + 1) % D);
          got  = int'($signed(samples[k*AMPW +: AMPW]));
          if (frac == '0)
            check(got == lo, "R6/R7/R10 exact address", got, lo);
          else begin
            check(got == lo || got == hi, "R5/R7/R10 dithered neighbour", got, lo);
            if (lo != hi) begin
              if (got == lo) hits_lo++;
              else if (got == hi) hits_hi++;
            end
          end
        end
      end
    end
  endtask

  task automatic write_inc(logic [PW-1:0] v);
    inc_we = 1'b1;
    inc_wdata = v;
    tick();
    inc_we = 1'b0;
  endtask

  initial begin
    logic [PW-1:0] lcg;
    // R1: outputs held at zero in reset.
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(valid == 1'b0, "R1 valid in reset", int'(valid), 0);
      check(samples == '0, "R1 samples in reset", int'(samples != '0), 0);
    end
    rst = 1'b0;
    live = 1'b1;
    // R2: latency of valid after release.
    @(negedge clk);
    check(valid == 1'b0, "R2 valid after first edge", int'(valid), 0);
    @(negedge clk);
    check(valid == 1'b1, "R2 valid after second edge", int'(valid), 1);
    for (int i = 0; i < 4; i++) tick();
    // R4/R6: one address per lane step, walks the full table exactly.
    write_inc(PW'(1 << DW));
    for (int i = 0; i < 40; i++) tick();
    // R9: fractional step, both neighbours must show.
    write_inc(PW'((3 << DW) + (1 << (DW - 1))));
    for (int i = 0; i < 300; i++) tick();
    check(hits_lo > 0, "R9 lower neighbour seen", hits_lo, 1);
    check(hits_hi > 0, "R9 upper neighbour seen", hits_hi, 1);
    // R4: negative step wraps the phase backwards.
    write_inc(PW'(-(5 << DW) - 123));
    for (int i = 0; i < 100; i++) tick();
    // R3: data without strobe is ignored.
    for (int i = 0; i < 20; i++) begin
      inc_wdata = PW'(16'hBEEF + i * 977);
      tick();
    end
    // R3: back-to-back step writes keep lanes coherent.
    lcg = 16'h1234;
    for (int i = 0; i < 30; i++) begin
      lcg = lcg * 16'd25173 + 16'd13849;
      write_inc(lcg);
    end
    for (int i = 0; i < 10; i++) tick();
    // R1: reset returns outputs to zero.
    rst = 1'b1;
    live = 1'b0;
    @(negedge clk);
    check(valid == 1'b0, "R1 valid on re-reset", int'(valid), 0);
    check(samples == '0, "R1 samples on re-reset", int'(samples != '0), 0);
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

endmodule